// File: doc/BRIEF.md
# Bit-Time Stamp Counter with Network Synchronisation

This block keeps a 16-bit time base for a CAN controller. The time base advances by one for every nominal bit time, which the protocol engine signals with a single-cycle tick. When a frame completes successfully, in either direction, the block records the current count together with the message-buffer index. It then presents that pair on a write port, so that the buffer RAM can store the value in the buffer's time-stamp word.

Buffer 0 has a special role. When the synchronisation control is set, a successful receive or transmit through buffer 0 clears the time base. Every node that handles the same message in buffer 0 then restarts its count from a common point on the bus. The stamp written for that event still carries the value from before the clear.

A receive completion and a transmit completion can arrive in the same cycle, for example in loopback. Each capture therefore passes through a small ordered queue, and the write port delivers at most one stamp per cycle.

Top module: `can_bittime_stamp`

## Requirements
- R1: While reset is asserted, and right after it, `count_o` is 0 and `stamp_we` is 0.
- R2: Each clock edge with `bit_tick` high and no synchronising clear adds one to `count_o`. Without a tick, and without a clear, `count_o` holds its value.
- R3: The count wraps from 0xFFFF to 0x0000 on the next tick and does not saturate.
- R4: A cycle with `rx_done` high is followed, one cycle later, by `stamp_we` high. `stamp_buf` then equals the receive index and `stamp_o` equals the count seen in the event cycle. This timing applies when no earlier stamp is still waiting.
- R5: Same as R4 for `tx_done` and the transmit index.
- R6: When `rx_done` and `tx_done` are high in the same cycle, the receive stamp is written first and the transmit stamp in the following cycle. Both stamps carry the same count. All stamps leave in event order.
- R7: With `sync_en` high, a receive or transmit completion on buffer index 0 makes `count_o` read 0 after that edge. The stamp for that event holds the count from before the clear.
- R8: With `sync_en` low, a completion on buffer 0 does not clear the count.
- R9: A completion on any non-zero buffer index never clears the count, even with `sync_en` high.
- R10: If a clear and a `bit_tick` fall on the same edge, the clear wins and `count_o` reads 0.
- R11: `stamp_we` is a one-cycle pulse for each capture. It is never high unless a capture is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_tick | input | 1 | One pulse per elapsed CAN bit time |
| rx_done | input | 1 | Successful reception strobe |
| rx_buf | input | 4 | Buffer index that accepted the received frame |
| tx_done | input | 1 | Successful transmission strobe |
| tx_buf | input | 4 | Buffer index that was transmitted |
| sync_en | input | 1 | Enables clearing of the count by buffer-0 traffic |
| count_o | output | 16 | Running bit-time count |
| stamp_o | output | 16 | Captured count for the time-stamp word |
| stamp_we | output | 1 | Write strobe for the time-stamp word |
| stamp_buf | output | 4 | Buffer index whose time-stamp word is written |

## Verification
Two collisions matter here. The first is a synchronising clear landing on the same edge as a bit tick. The bench drives a buffer-0 completion with the tick high and `sync_en` set, then expects the count to read 0 and the stamp to hold the value from before the clear. The second is receive and transmit completing together. The bench drives that collision, also with a single event in the next cycle, and the scoreboard requires the stamps to arrive one per cycle in rx, tx, then next-event order.

// File: rtl/can_ts_pkg.sv
package can_ts_pkg;

  localparam int DEF_TS_W  = 16;
  localparam int DEF_BUF_W = 4;

  // Kind of completion seen in one cycle
  typedef enum logic [1:0] {
    EV_NONE = 2'b00,
    EV_RX   = 2'b01,
    EV_TX   = 2'b10,
    EV_BOTH = 2'b11
  } ev_kind_t;

endpackage

// File: rtl/cts_bit_counter.sv
module cts_bit_counter #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            clear_i,
  output logic [TS_W-1:0] count_o
);

  logic [TS_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  // The clear takes priority over a tick on the same edge
  always_comb begin
    cnt_en = clear_i | tick_i;
    if (clear_i) cnt_d = '0;
    else         cnt_d = cnt_q + TS_W'(1);   // wraps naturally
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/cts_event_sel.sv
module cts_event_sel
  import can_ts_pkg::*;
#(
  parameter int BUF_W    = 4,
  parameter int SYNC_BUF = 0
) (
  input  logic             rx_done,
  input  logic [BUF_W-1:0] rx_buf,
  input  logic             tx_done,
  input  logic [BUF_W-1:0] tx_buf,
  input  logic             sync_en,
  output ev_kind_t         kind_o,
  output logic             clear_o
);

  localparam logic [BUF_W-1:0] SYNC_IDX = BUF_W'(SYNC_BUF);

  logic rx_on_sync, tx_on_sync;

  always_comb begin
    rx_on_sync = rx_done && (rx_buf == SYNC_IDX);
    tx_on_sync = tx_done && (tx_buf == SYNC_IDX);
    clear_o    = sync_en && (rx_on_sync || tx_on_sync);
    unique case ({tx_done, rx_done})
      2'b01:   kind_o = EV_RX;
      2'b10:   kind_o = EV_TX;
      2'b11:   kind_o = EV_BOTH;
      default: kind_o = EV_NONE;
    endcase
  end

endmodule

// File: rtl/cts_stamp_fifo.sv
module cts_stamp_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] data_a,
  input  logic         push_b,
  input  logic [W-1:0] data_b,
  output logic         valid_o,
  output logic [W-1:0] head_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [LW:0]   room;
  logic          acc_a, acc_b, pop;

  // Entry a is older than entry b; pushes beyond free room are dropped
  always_comb begin
    room  = (LW+1)'(DEPTH) - {1'b0, lvl_q};
    acc_a = push_a && (room != '0);
    acc_b = push_b && acc_a && (room > (LW+1)'(1));
    pop   = (lvl_q != '0);
    wr_d  = wr_q + PW'(acc_a) + PW'(acc_b);
    rd_d  = rd_q + PW'(pop);
    lvl_d = lvl_q + LW'(acc_a) + LW'(acc_b) - LW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic         sel_a, sel_b, slot_en;
    logic [W-1:0] slot_d;
    always_comb begin
      sel_a   = acc_a && (wr_q == PW'(i));
      sel_b   = acc_b && ((wr_q + PW'(1)) == PW'(i));
      slot_en = sel_a | sel_b;
      slot_d  = sel_a ? data_a : data_b;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[i] <= '0;
      else if (slot_en) mem[i] <= slot_d;
    end
  end

  assign valid_o = pop;
  assign head_o  = mem[rd_q];

endmodule

// File: rtl/can_bittime_stamp.sv
module can_bittime_stamp
  import can_ts_pkg::*;
#(
  parameter int TS_W     = DEF_TS_W,
  parameter int BUF_W    = DEF_BUF_W,
  parameter int SYNC_BUF = 0,
  parameter int Q_DEPTH  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_done,
  input  logic [BUF_W-1:0] rx_buf,
  input  logic             tx_done,
  input  logic [BUF_W-1:0] tx_buf,
  input  logic             sync_en,
  output logic [TS_W-1:0]  count_o,
  output logic [TS_W-1:0]  stamp_o,
  output logic             stamp_we,
  output logic [BUF_W-1:0] stamp_buf
);

  localparam int ITEM_W = BUF_W + TS_W;

  ev_kind_t          kind;
  logic              clear;
  logic [TS_W-1:0]   cnt;
  logic              push_a, push_b;
  logic [ITEM_W-1:0] item_a, item_b, head;
  logic              head_vld;

  cts_event_sel #(.BUF_W(BUF_W), .SYNC_BUF(SYNC_BUF)) u_sel (
    .rx_done (rx_done),
    .rx_buf  (rx_buf),
    .tx_done (tx_done),
    .tx_buf  (tx_buf),
    .sync_en (sync_en),
    .kind_o  (kind),
    .clear_o (clear)
  );

  cts_bit_counter #(.TS_W(TS_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (bit_tick),
    .clear_i (clear),
    .count_o (cnt)
  );

  // The capture uses the count from before this edge, so a buffer-0
  // event stamps the value that is about to be cleared
  always_comb begin
    push_a = (kind != EV_NONE);
    push_b = (kind == EV_BOTH);
    item_a = (kind == EV_TX) ? {tx_buf, cnt} : {rx_buf, cnt};
    item_b = {tx_buf, cnt};
  end

  cts_stamp_fifo #(.W(ITEM_W), .DEPTH(Q_DEPTH)) u_q (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_a  (push_a),
    .data_a  (item_a),
    .push_b  (push_b),
    .data_b  (item_b),
    .valid_o (head_vld),
    .head_o  (head)
  );

  assign count_o   = cnt;
  assign stamp_we  = head_vld;
  assign stamp_o   = head[TS_W-1:0];
  assign stamp_buf = head[ITEM_W-1:TS_W];

endmodule

// File: rtl/cts_checker.sv
module cts_checker #(
  parameter int TS_W     = 16,
  parameter int BUF_W    = 4,
  parameter int SYNC_BUF = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_tick,
  input logic             rx_done,
  input logic [BUF_W-1:0] rx_buf,
  input logic             tx_done,
  input logic [BUF_W-1:0] tx_buf,
  input logic             sync_en,
  input logic [TS_W-1:0]  count_o,
  input logic [TS_W-1:0]  stamp_o,
  input logic             stamp_we,
  input logic [BUF_W-1:0] stamp_buf
);

  logic hit;
  assign hit = sync_en && ((rx_done && rx_buf == BUF_W'(SYNC_BUF)) ||
                           (tx_done && tx_buf == BUF_W'(SYNC_BUF)));

  a_r2_tick_adds: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick && !hit |=> count_o == $past(count_o) + TS_W'(1));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick && !hit |=> $stable(count_o));

  a_r7_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> count_o == '0);

  a_r10_clear_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
    hit && bit_tick |=> count_o == '0);

  a_r4_rx_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !stamp_we |=> stamp_we && stamp_buf == $past(rx_buf)
                              && stamp_o == $past(count_o));

  a_r5_tx_stamp: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !rx_done && !stamp_we |=> stamp_we && stamp_buf == $past(tx_buf)
                                         && stamp_o == $past(count_o));

  a_r6_tx_second: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && tx_done && !stamp_we |=> ##1 (stamp_we && stamp_buf == $past(tx_buf, 2)));

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_we && !rx_done && !tx_done |=> !stamp_we);

  always_comb begin
    if (!rst_n) a_r1_reset_quiet: assert (!stamp_we);
  end

endmodule

bind can_bittime_stamp cts_checker #(
  .TS_W(TS_W), .BUF_W(BUF_W), .SYNC_BUF(SYNC_BUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
  .rx_done(rx_done), .rx_buf(rx_buf), .tx_done(tx_done), .tx_buf(tx_buf),
  .sync_en(sync_en), .count_o(count_o), .stamp_o(stamp_o),
  .stamp_we(stamp_we), .stamp_buf(stamp_buf)
);

// File: tb/can_bittime_stamp_bench.sv
module can_bittime_stamp_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, bit_tick, rx_done, tx_done, sync_en;
  logic [3:0]  rx_buf, tx_buf, stamp_buf;
  logic [15:0] count_o, stamp_o;
  logic        stamp_we;

  int compared = 0;
  int mismatched = 0;
  logic [15:0] model = '0;
  logic [19:0] exp_q[$];
  string       tag_q[$];

  can_bittime_stamp u_can_bittime_stamp (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .rx_done(rx_done), .rx_buf(rx_buf), .tx_done(tx_done), .tx_buf(tx_buf),
    .sync_en(sync_en), .count_o(count_o), .stamp_o(stamp_o),
    .stamp_we(stamp_we), .stamp_buf(stamp_buf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected stamps as the write port produces them
  always @(negedge clk) begin
    if (rst_n && stamp_we) begin
      if (exp_q.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R11: actual stamp %0h/%0h expected none", stamp_buf, stamp_o);
      end else begin
        logic [19:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {12'h0, stamp_buf, stamp_o}, {12'h0, e});
      end
    end
  end

  // Driver: one cycle of stimulus, called at a falling edge
  task automatic step(input logic t, input logic rx, input logic [3:0] rb,
                      input logic tx, input logic [3:0] tb, input logic se,
                      input string tag);
    logic sh;
    bit_tick = t; rx_done = rx; rx_buf = rb;
    tx_done = tx; tx_buf = tb; sync_en = se;
    sh = se && ((rx && rb == 4'd0) || (tx && tb == 4'd0));
    if (rx) begin exp_q.push_back({rb, model}); tag_q.push_back(tag); end
    if (tx) begin exp_q.push_back({tb, model}); tag_q.push_back(tag); end
    @(posedge clk);
    if (sh)     model = '0;
    else if (t) model = model + 16'd1;
    @(negedge clk);
    bit_tick = 0; rx_done = 0; tx_done = 0;
    chk(tag, {16'h0, count_o}, {16'h0, model});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; bit_tick = 0; rx_done = 0; tx_done = 0;
    rx_buf = 0; tx_buf = 0; sync_en = 0;
    repeat (3) @(negedge clk);
    chk("R1", {16'h0, count_o}, 32'h0);
    chk("R1", {31'h0, stamp_we}, 32'h0);
    @(posedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1", {16'h0, count_o}, 32'h0);

    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 1, 4'd3, 0, 0, 0, "R4");
    step(1, 0, 0, 1, 4'd7, 0, "R5");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(1, 1, 4'd2, 1, 4'd5, 0, "R6");
    step(1, 1, 4'd9, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 1, 4'd0, 0, 0, 1, "R10");
    step(1, 1, 4'd0, 0, 0, 1, "R7");
    step(1, 0, 0, 0, 0, 1, "R2");
    step(1, 0, 0, 0, 0, 1, "R2");
    step(1, 0, 0, 1, 4'd0, 0, "R8");
    step(1, 1, 4'd4, 0, 0, 1, "R9");
    step(0, 0, 0, 1, 4'd0, 1, "R7");
    step(1, 1, 4'd1, 0, 0, 1, "R2");
    step(1, 1, 4'd0, 1, 4'd3, 1, "R7");
    for (int i = 0; i < 65535; i++) step(1, 0, 0, 0, 0, 0, "R3");
    chk("R3", {16'h0, count_o}, 32'h0000FFFF);
    step(1, 0, 0, 1, 4'd6, 0, "R3");
    chk("R3", {16'h0, count_o}, 32'h0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R11");
    chk("R11", exp_q.size(), 0);
    finish_run();
  end

endmodule